// File: doc/BRIEF.md
# Event-Triggered Memory Move Engine

This block copies data from one memory location to another, one unit per hardware event. Before a move, a set of descriptors is loaded through a simple register-write port. Each descriptor holds a 24-bit source address, a 24-bit destination address, a 16-bit unit count, a size bit (byte or 16-bit word) and two control bits. An event that arrives while the engine is idle and armed starts descriptor 0. The engine reads one unit from the source and writes it to the destination over a single-master valid/ready bus. It then steps both addresses and decrements the count.

The control bits decide what happens after each unit. The per-unit interrupt bit raises an interrupt after every unit. When it is clear, an interrupt is raised only when the count runs out. On that final unit the engine also disarms itself and pulses an event-clear output. A descriptor with its chain bit set skips all of this end-of-count handling. Instead, the engine moves straight on to the next descriptor within the same event. A word descriptor with an odd address is rejected before any bus access.

The controller moves through five named states. IDLE waits for an armed event. CHECK validates alignment. READ holds a read request until it is accepted. WRITE holds the write request. UPDATE writes back the descriptor. The transitions are: IDLE to CHECK on an armed event, CHECK to IDLE on misalignment, CHECK to READ otherwise, READ to WRITE and WRITE to UPDATE on bus acceptance, UPDATE to CHECK when chaining to a further descriptor, and UPDATE to IDLE otherwise.

Top module: `evt_xfer_engine`

## Requirements
- R1: After reset the engine is idle and disarmed: `busy`, `bus_valid`, `irq`, `evt_clr` and `armed` are 0, and an event arriving while disarmed causes no bus access.
- R2: Configuration fields are written with `cfg_field` codes 0 source, 1 destination, 2 count (`cfg_wdata[15:0]`), 3 size (`cfg_wdata[0]`, 1 = word), 4 control (`cfg_wdata[7]` chain, `cfg_wdata[6]` per-unit interrupt) and 5 arm (`cfg_wdata[0]`). Each unit is a read of the source followed by a write of that data to the destination. Byte data travels on bits 7:0, and word data is little-endian on bits 15:0 with `bus_size` = 1. A request is held stable until `bus_ready`.
- R3: After each unit, the source and destination addresses advance by 1 for byte size and by 2 for word size.
- R4: The count decrements by one per unit, and a loaded count of 0 acts as 65,536 (it does not end after the first unit).
- R5: With the per-unit interrupt bit set, `irq` pulses for one cycle after every unit.
- R6: With the chain bit clear and the per-unit bit clear, `irq` pulses only on the unit that brings the count to zero. That unit also pulses `evt_clr` and clears `armed`, whatever the per-unit bit.
- R7: With the chain bit set, reaching zero causes no disarm and no `evt_clr`, and the engine proceeds to the next descriptor in the same event without a new event. After the last descriptor it returns to IDLE.
- R8: Control bits 5:0 have no effect on operation.
- R9: A word descriptor with an odd source or destination address pulses `addr_err`, performs no bus access, and leaves its addresses and count unchanged.
- R10: `busy` is high from the cycle after an event is accepted until the return to IDLE, and events arriving while busy are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_desc | input | IDX_W | Descriptor index for the write |
| cfg_field | input | 3 | Field code (see R2) |
| cfg_wdata | input | 24 | Write data |
| evt_req | input | 1 | Hardware event request |
| evt_clr | output | 1 | Pulse clearing the event source at end of count |
| armed | output | 1 | Event enable state |
| busy | output | 1 | Engine is processing an event |
| irq | output | 1 | Interrupt request pulse |
| addr_err | output | 1 | Misaligned word descriptor pulse |
| bus_valid | output | 1 | Bus request valid |
| bus_write | output | 1 | 1 = write, 0 = read |
| bus_size | output | 1 | 1 = word, 0 = byte |
| bus_addr | output | 24 | Bus address |
| bus_wdata | output | 16 | Write data |
| bus_ready | input | 1 | Request accepted this cycle |
| bus_rdata | input | 16 | Read data, valid with `bus_ready` on a read |

## Verification
A corrupted address or count register shows up at the bus on the next unit, as bytes landing at the wrong place in the bench memory. It can also show as an interrupt or disarm that comes one event early or late, which the bench sees right after that event settles. A wrong controller state is visible within a few cycles. It can appear as a bus request while idle, a request that changes before acceptance, a missing or doubled write, or a chain that fails to continue. Random descriptors with random bus stalls are compared event by event against a bench model of the memory, interrupt, clear and error counts.

// File: rtl/xfer_pkg.sv
package xfer_pkg;
    localparam int ADDR_W  = 24;
    localparam int CNT_W   = 16;
    localparam int DATA_W  = 16;
    localparam int FIELD_W = 3;

    localparam logic [FIELD_W-1:0] F_SRC  = 3'd0;
    localparam logic [FIELD_W-1:0] F_DST  = 3'd1;
    localparam logic [FIELD_W-1:0] F_CNT  = 3'd2;
    localparam logic [FIELD_W-1:0] F_SIZE = 3'd3;
    localparam logic [FIELD_W-1:0] F_CTRL = 3'd4;
    localparam logic [FIELD_W-1:0] F_ARM  = 3'd5;

    localparam int CTRL_CHAIN_BIT = 7;
    localparam int CTRL_ISEL_BIT  = 6;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_READ,
        S_WRITE,
        S_UPDATE
    } xfer_state_t;

    typedef struct packed {
        logic [ADDR_W-1:0] src;
        logic [ADDR_W-1:0] dst;
        logic [CNT_W-1:0]  cnt;
        logic              word;
        logic              chain;
        logic              isel;
    } xfer_desc_t;
endpackage

// File: rtl/xfer_desc_regs.sv
module xfer_desc_regs
    import xfer_pkg::*;
#(
    parameter int NUM_DESC = 2,
    parameter int IDX_W    = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_idx,
    input  logic [FIELD_W-1:0] cfg_field,
    input  logic [ADDR_W-1:0]  cfg_wdata,
    input  logic               upd_en,
    input  logic [IDX_W-1:0]   upd_idx,
    input  logic [ADDR_W-1:0]  upd_src,
    input  logic [ADDR_W-1:0]  upd_dst,
    input  logic [CNT_W-1:0]   upd_cnt,
    input  logic               disarm,
    input  logic [IDX_W-1:0]   rd_idx,
    output xfer_desc_t         rd_desc,
    output logic               armed
);
    xfer_desc_t ent [NUM_DESC];

    for (genvar i = 0; i < NUM_DESC; i++) begin : g_ent
        xfer_desc_t q;
        logic hit_upd;
        logic hit_cfg;

        assign hit_upd = upd_en && (upd_idx == IDX_W'(i));
        assign hit_cfg = cfg_we && (cfg_idx == IDX_W'(i));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q <= '0;
            end else if (hit_upd) begin
                q.src <= upd_src;
                q.dst <= upd_dst;
                q.cnt <= upd_cnt;
            end else if (hit_cfg) begin
                case (cfg_field)
                    F_SRC:   q.src  <= cfg_wdata;
                    F_DST:   q.dst  <= cfg_wdata;
                    F_CNT:   q.cnt  <= cfg_wdata[CNT_W-1:0];
                    F_SIZE:  q.word <= cfg_wdata[0];
                    F_CTRL: begin
                        q.chain <= cfg_wdata[CTRL_CHAIN_BIT];
                        q.isel  <= cfg_wdata[CTRL_ISEL_BIT];
                    end
                    default: ;
                endcase
            end
        end

        assign ent[i] = q;
    end

    assign rd_desc = ent[rd_idx];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            armed <= 1'b0;
        end else if (disarm) begin
            armed <= 1'b0;
        end else if (cfg_we && cfg_field == F_ARM) begin
            armed <= cfg_wdata[0];
        end
    end
endmodule

// File: rtl/xfer_fsm.sv
module xfer_fsm
    import xfer_pkg::*;
#(
    parameter int NUM_DESC = 2,
    parameter int IDX_W    = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              evt_req,
    input  logic              armed,
    input  xfer_desc_t        desc,
    input  logic              bus_ready,
    input  logic [DATA_W-1:0] bus_rdata,
    output logic [IDX_W-1:0]  cur_idx,
    output logic              upd_en,
    output logic [ADDR_W-1:0] upd_src,
    output logic [ADDR_W-1:0] upd_dst,
    output logic [CNT_W-1:0]  upd_cnt,
    output logic              disarm,
    output logic              busy,
    output logic              irq,
    output logic              evt_clr,
    output logic              addr_err,
    output logic              bus_valid,
    output logic              bus_write,
    output logic              bus_size,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata
);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

    xfer_state_t state, state_nx;
    logic [DATA_W-1:0] data_q;
    logic misalign;
    logic count_done;
    logic end_work;
    logic more_chain;
    logic [ADDR_W-1:0] step;
    logic [CNT_W-1:0] cnt_dec;

    assign misalign   = desc.word && (desc.src[0] || desc.dst[0]);
    assign step       = desc.word ? ADDR_W'(2) : ADDR_W'(1);
    assign cnt_dec    = desc.cnt - CNT_W'(1);
    assign count_done = (cnt_dec == '0);
    assign more_chain = desc.chain && (cur_idx != LAST_IDX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:   if (evt_req && armed) state_nx = S_CHECK;
            S_CHECK:  state_nx = misalign ? S_IDLE : S_READ;
            S_READ:   if (bus_ready) state_nx = S_WRITE;
            S_WRITE:  if (bus_ready) state_nx = S_UPDATE;
            S_UPDATE: state_nx = more_chain ? S_CHECK : S_IDLE;
            default:  state_nx = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_idx <= '0;
            data_q  <= '0;
        end else begin
            if (state == S_IDLE) cur_idx <= '0;
            else if (state == S_UPDATE && more_chain) cur_idx <= cur_idx + IDX_W'(1);
            if (state == S_READ && bus_ready)
                data_q <= desc.word ? bus_rdata : {8'h00, bus_rdata[7:0]};
        end
    end

    always_comb begin
        end_work  = (state == S_UPDATE) && !desc.chain && count_done;
        busy      = (state != S_IDLE);
        bus_valid = (state == S_READ) || (state == S_WRITE);
        bus_write = (state == S_WRITE);
        bus_size  = desc.word;
        bus_addr  = (state == S_WRITE) ? desc.dst : desc.src;
        bus_wdata = data_q;
        addr_err  = (state == S_CHECK) && misalign;
        upd_en    = (state == S_UPDATE);
        upd_src   = desc.src + step;
        upd_dst   = desc.dst + step;
        upd_cnt   = cnt_dec;
        disarm    = end_work;
        evt_clr   = end_work;
        irq       = (state == S_UPDATE) && (desc.isel || end_work);
    end
endmodule

// File: rtl/evt_xfer_engine.sv
module evt_xfer_engine
    import xfer_pkg::*;
#(
    parameter int NUM_DESC = 2,
    localparam int IDX_W = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [IDX_W-1:0]   cfg_desc,
    input  logic [FIELD_W-1:0] cfg_field,
    input  logic [ADDR_W-1:0]  cfg_wdata,
    input  logic               evt_req,
    output logic               evt_clr,
    output logic               armed,
    output logic               busy,
    output logic               irq,
    output logic               addr_err,
    output logic               bus_valid,
    output logic               bus_write,
    output logic               bus_size,
    output logic [ADDR_W-1:0]  bus_addr,
    output logic [DATA_W-1:0]  bus_wdata,
    input  logic               bus_ready,
    input  logic [DATA_W-1:0]  bus_rdata
);
    xfer_desc_t        cur_desc;
    logic [IDX_W-1:0]  cur_idx;
    logic              upd_en;
    logic [ADDR_W-1:0] upd_src;
    logic [ADDR_W-1:0] upd_dst;
    logic [CNT_W-1:0]  upd_cnt;
    logic              disarm;

    xfer_desc_regs #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_idx(cfg_desc), .cfg_field(cfg_field), .cfg_wdata(cfg_wdata),
        .upd_en(upd_en), .upd_idx(cur_idx), .upd_src(upd_src), .upd_dst(upd_dst),
        .upd_cnt(upd_cnt), .disarm(disarm), .rd_idx(cur_idx),
        .rd_desc(cur_desc), .armed(armed)
    );

    xfer_fsm #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .evt_req(evt_req), .armed(armed), .desc(cur_desc),
        .bus_ready(bus_ready), .bus_rdata(bus_rdata), .cur_idx(cur_idx),
        .upd_en(upd_en), .upd_src(upd_src), .upd_dst(upd_dst), .upd_cnt(upd_cnt),
        .disarm(disarm), .busy(busy), .irq(irq), .evt_clr(evt_clr), .addr_err(addr_err),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata)
    );
endmodule

// File: rtl/xfer_engine_checker.sv
module xfer_engine_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        busy,
    input logic        armed,
    input logic        irq,
    input logic        evt_clr,
    input logic        addr_err,
    input logic        bus_valid,
    input logic        bus_ready,
    input logic        bus_write,
    input logic        bus_size,
    input logic [23:0] bus_addr
);
    a_r1_idle_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !bus_valid);

    a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && !bus_ready |=> bus_valid && $stable(bus_addr) && $stable(bus_write));

    a_r3_word_even: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid && bus_size |-> !bus_addr[0]);

    a_r9_err_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        addr_err |-> busy && !bus_valid);

    a_r6_clr_with_irq: assert property (@(posedge clk) disable iff (!rst_n)
        evt_clr |-> irq);

    a_r6_clr_disarms: assert property (@(posedge clk) disable iff (!rst_n)
        evt_clr |=> !armed);
endmodule

bind evt_xfer_engine xfer_engine_checker u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .armed(armed), .irq(irq),
    .evt_clr(evt_clr), .addr_err(addr_err), .bus_valid(bus_valid),
    .bus_ready(bus_ready), .bus_write(bus_write), .bus_size(bus_size),
    .bus_addr(bus_addr)
);

// File: tb/evt_xfer_engine_test.sv
module evt_xfer_engine_test;
    localparam int ND = 2;
    localparam int MEMSZ = 4096;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 1'b0;
    logic [0:0] cfg_desc = '0;
    logic [2:0] cfg_field = '0;
    logic [23:0] cfg_wdata = '0;
    logic evt_req = 1'b0;
    logic evt_clr, armed, busy, irq, addr_err;
    logic bus_valid, bus_write, bus_size;
    logic [23:0] bus_addr;
    logic [15:0] bus_wdata;
    logic bus_ready = 1'b1;
    logic [15:0] bus_rdata;

    logic [7:0] mem [MEMSZ];
    logic [7:0] exp_mem [MEMSZ];

    logic [23:0] sh_src [ND];
    logic [23:0] sh_dst [ND];
    logic [15:0] sh_cnt [ND];
    logic sh_word [ND];
    logic sh_chain [ND];
    logic sh_isel [ND];
    logic sh_en;

    int checks = 0, errors = 0;
    int irq_seen = 0, clr_seen = 0, err_seen = 0, wr_seen = 0;
    int exp_irq = 0, exp_clr = 0, exp_err = 0, exp_wr = 0;
    bit done = 0;

    always #10 clk = ~clk;

    evt_xfer_engine #(.NUM_DESC(ND)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_desc(cfg_desc),
        .cfg_field(cfg_field), .cfg_wdata(cfg_wdata), .evt_req(evt_req),
        .evt_clr(evt_clr), .armed(armed), .busy(busy), .irq(irq), .addr_err(addr_err),
        .bus_valid(bus_valid), .bus_write(bus_write), .bus_size(bus_size),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ready(bus_ready),
        .bus_rdata(bus_rdata)
    );

    assign bus_rdata = {mem[bus_addr[11:0] + 12'd1], mem[bus_addr[11:0]]};

    always @(posedge clk) begin
        if (rst_n) begin
            if (irq) irq_seen++;
            if (evt_clr) clr_seen++;
            if (addr_err) err_seen++;
            if (bus_valid && bus_ready && bus_write) begin
                wr_seen++;
                mem[bus_addr[11:0]] <= bus_wdata[7:0];
                if (bus_size) mem[bus_addr[11:0] + 12'd1] <= bus_wdata[15:8];
            end
        end
    end

    always @(negedge clk) bus_ready <= ($urandom % 4) != 0;

    task automatic check(input bit ok, input string req, input int act, input int expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, expv);
        end
    endtask

    task automatic cfg_write(input int idx, input logic [2:0] fld, input logic [23:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_desc = idx[0:0]; cfg_field = fld; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
        case (fld)
            3'd0: sh_src[idx] = d;
            3'd1: sh_dst[idx] = d;
            3'd2: sh_cnt[idx] = d[15:0];
            3'd3: sh_word[idx] = d[0];
            3'd4: begin sh_chain[idx] = d[7]; sh_isel[idx] = d[6]; end
            3'd5: sh_en = d[0];
            default: ;
        endcase
    endtask

    task automatic load_desc(input int idx, input logic [23:0] s, input logic [23:0] t,
                             input logic [15:0] n, input bit w, input logic [7:0] ctrl);
        cfg_write(idx, 3'd0, s);
        cfg_write(idx, 3'd1, t);
        cfg_write(idx, 3'd2, {8'h00, n});
        cfg_write(idx, 3'd3, {23'd0, w});
        cfg_write(idx, 3'd4, {16'd0, ctrl});
    endtask

    task automatic model_event();
        int d = 0;
        if (!sh_en) return;
        forever begin
            int n;
            logic [7:0] tmp [2];
            if (sh_word[d] && (sh_src[d][0] || sh_dst[d][0])) begin
                exp_err++;
                return;
            end
            n = sh_word[d] ? 2 : 1;
            for (int k = 0; k < n; k++) tmp[k] = exp_mem[(sh_src[d] + k) & 24'hFFF];
            for (int k = 0; k < n; k++) exp_mem[(sh_dst[d] + k) & 24'hFFF] = tmp[k];
            exp_wr++;
            sh_src[d] = sh_src[d] + n;
            sh_dst[d] = sh_dst[d] + n;
            sh_cnt[d] = sh_cnt[d] - 16'd1;
            if (sh_chain[d]) begin
                if (sh_isel[d]) exp_irq++;
                if (d < ND - 1) d++;
                else return;
            end else begin
                if (sh_cnt[d] == 16'd0) begin
                    exp_irq++; exp_clr++; sh_en = 0;
                end else if (sh_isel[d]) begin
                    exp_irq++;
                end
                return;
            end
        end
    endtask

    task automatic run_event(input string tag, input bit hold_extra);
        bit start_exp;
        bit busy_seen = 0;
        int mism = 0;
        bit can_hold;
        start_exp = sh_en;
        can_hold = hold_extra && !(sh_word[0] && (sh_src[0][0] || sh_dst[0][0]));
        model_event();
        @(negedge clk);
        evt_req = 1'b1;
        @(negedge clk);
        if (busy) busy_seen = 1;
        if (can_hold) begin
            @(negedge clk);
            if (busy) busy_seen = 1;
        end
        evt_req = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        for (int a = 0; a < MEMSZ; a++) if (mem[a] !== exp_mem[a]) mism++;
        check(mism == 0, {tag, " R2 R3 memory"}, mism, 0);
        check(wr_seen == exp_wr, {tag, " R10 writes"}, wr_seen, exp_wr);
        check(busy_seen == start_exp, {tag, " R10 busy"}, busy_seen, start_exp);
        check(irq_seen == exp_irq, {tag, " R5 R6 irq"}, irq_seen, exp_irq);
        check(clr_seen == exp_clr, {tag, " R6 R7 clr"}, clr_seen, exp_clr);
        check(armed == sh_en, {tag, " R6 armed"}, armed, sh_en);
        check(err_seen == exp_err, {tag, " R9 err"}, err_seen, exp_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2718));
        for (int a = 0; a < MEMSZ; a++) begin
            mem[a] = 8'($urandom);
            exp_mem[a] = mem[a];
        end
        for (int i = 0; i < ND; i++) begin
            sh_src[i] = '0; sh_dst[i] = '0; sh_cnt[i] = '0;
            sh_word[i] = 0; sh_chain[i] = 0; sh_isel[i] = 0;
        end
        sh_en = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(!busy && !bus_valid && !irq && !evt_clr && !armed, "R1 reset outputs",
              {busy, bus_valid, irq, evt_clr, armed}, 0);
        load_desc(0, 24'h100, 24'h200, 16'd2, 0, 8'h00);
        run_event("R1 disarmed", 0);

        // R2 R3 byte units, R6 end of count
        cfg_write(0, 3'd5, 24'd1);
        run_event("R2 byte first", 0);
        run_event("R6 byte last", 0);

        // R3 word stepping, R5 per-unit irq, R10 held event
        load_desc(0, 24'h300, 24'h402, 16'd3, 1, 8'h40);
        cfg_write(0, 3'd5, 24'd1);
        run_event("R3 word", 1);
        run_event("R5 word", 1);
        run_event("R5 word last", 0);

        // R4 zero count means 65536
        load_desc(0, 24'h500, 24'h600, 16'd0, 0, 8'h00);
        cfg_write(0, 3'd5, 24'd1);
        for (int e = 0; e < 3; e++) run_event("R4 zero count", 0);

        // R7 chain to next descriptor
        load_desc(0, 24'h700, 24'h780, 16'd1, 0, 8'h80);
        load_desc(1, 24'h800, 24'h880, 16'd1, 1, 8'h00);
        cfg_write(0, 3'd5, 24'd1);
        run_event("R7 chain", 0);

        // R8 reserved control bits
        load_desc(0, 24'h900, 24'h980, 16'd2, 0, 8'h3F);
        cfg_write(0, 3'd5, 24'd1);
        run_event("R8 reserved", 0);

        // R9 misaligned word
        load_desc(0, 24'hA01, 24'hB00, 16'd2, 1, 8'h40);
        cfg_write(0, 3'd5, 24'd1);
        run_event("R9 odd src", 0);
        cfg_write(0, 3'd0, 24'hA00);
        cfg_write(0, 3'd1, 24'hB03);
        run_event("R9 odd dst", 0);

        // random mix
        for (int it = 0; it < 25; it++) begin
            for (int d = 0; d < ND; d++) begin
                bit w = $urandom % 2;
                logic [23:0] s = 24'($urandom % 24'hE00);
                logic [23:0] t = 24'($urandom % 24'hE00);
                logic [7:0] c = 8'($urandom) & 8'hFF;
                if (d == ND - 1) c[7] = 1'b0;
                if (w && ($urandom % 8 != 0)) begin s[0] = 1'b0; t[0] = 1'b0; end
                load_desc(d, s, t, 16'(1 + $urandom % 4), w, c);
            end
            cfg_write(0, 3'd5, 24'd1);
            for (int e = 0; e < 5; e++) begin
                if (!sh_en) break;
                run_event("R7 R8 random", $urandom % 2);
            end
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule